// File: doc/BRIEF.md
# SD Card SPI Host Port with Timeout

This block gives an 8-bit host bus a small window of eight byte-wide registers through which software can talk to an SD card over SPI. The bus side sees an already decoded 3-bit register select, active-low read and write strobes, a write data byte and a read data byte. The card side sees a serial clock, a serial output, a serial input and an active-low chip select. Deciding which bus cycles belong to this port is left to the surrounding logic.

Writing the transfer register sends that byte to the card while the card's reply is shifted in. Reading the same register also starts an exchange, but sends all ones so that software can clock data out of the card with one bus read per byte. A busy output stays high while an exchange runs, and the bus logic waits on it before it takes the read data. The control register sets the chip-select level, which reaches the pin only once the write strobe is released. Five scratch bytes hold software state. The timer register arms a millisecond timeout that software polls.

Top module: `sdspi_port`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 1, busy is 0, every scratch byte reads 0, and the timer register reads 1 (limit 0, count 0).
- R2: A committed write to select 0 starts an SPI mode 0 exchange of the written byte, MSB first: exactly 8 sclk pulses, each level lasting CLK_DIV clock cycles, mosi stable at every rising sclk edge, busy high for the whole exchange, and sclk low whenever busy is low.
- R3: A falling edge of rd_n with select 0 starts an exchange that sends 0xFF; once busy falls, rdata with select 0 holds the 8 bits sampled from miso on the rising sclk edges, first bit in bit 7.
- R4: A start request (read or write of select 0) that arrives while busy is high is ignored; busy lasts no more than 16*CLK_DIV cycles.
- R5: Reads of select 1 return the parameter CFG_BYTE, and a write to select 1 does not change that value.
- R6: A write to select 1 sets the chip-select level to bit 0 of the data byte (0 drives cs_n low); cs_n keeps its old value while wr_n is low and takes the new value on the first clock edge at which wr_n is seen high again.
- R7: Selects 2 to 6 are five independent read/write bytes; a write to one leaves the others unchanged.
- R8: Write data is taken on the clock edge SETTLE_CYCLES cycles after the first edge at which wr_n is seen low; values on wdata before or after that edge are not stored.
- R9: A write of value n to select 7 clears the timeout count and its tick prescaler and sets the limit to 10*n; the count then rises by one every TICK_CYCLES cycles, and select 7 reads 1 while count >= limit and 0 otherwise (bits 7 to 1 read 0).
- R10: The timeout count saturates at its maximum and never wraps, so an expired timer stays expired until the next write to select 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Decoded register select within the port |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the selected register |
| busy | output | 1 | High while an SPI exchange is in progress |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI serial data to the card |
| miso | input | 1 | SPI serial data from the card |
| cs_n | output | 1 | Card chip select, active low |

## Verification
The bench builds the block with CLK_DIV of 2, TICK_CYCLES of 4, SETTLE_CYCLES of 3 and a 12-bit count. A short exchange lets it send and receive every one of the 256 byte values in both the write-started and read-started forms, against a bench model of the card. The four-cycle tick puts exact expiry edges for several limits, and saturation of the full count range, within a few tens of thousands of cycles. The three-cycle settling delay makes the sampling edge for write data and the late update of chip select observable cycle by cycle.

// File: rtl/sdspi_pkg.sv
// Shared definitions for the SD card SPI host port.
// Assumes a 3-bit select that has already been decoded to this port.
package sdspi_pkg;

    // Register selects whose positions the port decodes.
    typedef enum logic [2:0] {
        SDP_XFER     = 3'd0,
        SDP_CTRL     = 3'd1,
        SDP_SCR_BASE = 3'd2,
        SDP_TIMER    = 3'd7
    } sdp_sel_e;

    localparam int SDP_NUM_SCR = 5;
    localparam logic [7:0] SDP_IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/sdspi_shift.sv
// SPI mode 0 byte exchanger, MSB first.
// Accepts start only when idle; each sclk level lasts DIV clock cycles.
// Assumes miso is stable around the rising sclk edge.
module sdspi_shift #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    // Exchange sequencer: phase timing, bit shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '1;
            rx_sh   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                tx_sh   <= tx_byte;
                div_cnt <= '0;
                bit_cnt <= '0;
                sclk    <= 1'b0;
            end
        end else if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            if (!sclk) begin
                sclk  <= 1'b1;
                rx_sh <= {rx_sh[6:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bit_cnt == 3'd7) begin
                    busy  <= 1'b0;
                    tx_sh <= '1;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                    tx_sh   <= {tx_sh[6:0], 1'b1};
                end
            end
        end else begin
            div_cnt <= div_cnt + DW'(1);
        end
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

endmodule

// File: rtl/sdspi_timer.sv
// Timeout counter with tick prescaler and programmable limit.
// The limit is ten times the loaded byte; the count saturates.
// Assumes CNT_W >= LIM_W so any limit is reachable.
module sdspi_timer #(
    parameter int TICK  = 50000,
    parameter int LIM_W = 12,
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [7:0] lim_in,
    output logic       expired
);
    localparam int PW = (TICK > 1) ? $clog2(TICK) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK - 1);

    logic [PW-1:0]    pre;
    logic [CNT_W-1:0] count;
    logic [LIM_W-1:0] limit;

    // Prescaler: one tick every TICK cycles, restarted by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre <= '0;
        else if (pre == PRE_LAST) pre <= '0;
        else pre <= pre + PW'(1);
    end

    // Count ticks up to saturation; clear and reload the limit on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            limit <= '0;
        end else if (clr) begin
            count <= '0;
            limit <= LIM_W'(lim_in) * LIM_W'(10);
        end else if (pre == PRE_LAST && count != '1) begin
            count <= count + CNT_W'(1);
        end
    end

    assign expired = (count >= CNT_W'(limit));

endmodule

// File: rtl/sdspi_port.sv
// Bus-facing register window for an SD card SPI host.
// Detects strobe edges, samples write data after a settling delay,
// holds chip select and scratch bytes, and muxes the read data.
// Assumes rd_n, wr_n, reg_sel and wdata are synchronous to clk.
module sdspi_port
    import sdspi_pkg::*;
#(
    parameter int         CLK_DIV       = 4,
    parameter int         TICK_CYCLES   = 50000,
    parameter int         SETTLE_CYCLES = 3,
    parameter int         CNT_W         = 12,
    parameter logic [7:0] CFG_BYTE      = 8'h5C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_sel,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       busy,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       cs_n
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

    logic          wr_q, rd_q;
    logic          pend;
    logic [SW-1:0] settle_cnt;
    logic          commit;
    logic          cs_pend;
    logic          spi_start;
    logic [7:0]    spi_tx;
    logic [7:0]    rx_byte;
    logic          expired_w;
    logic          tmr_clr;
    logic [SDP_NUM_SCR-1:0][7:0] scr;

    wire wr_fall = wr_q & ~wr_n;
    wire wr_rise = ~wr_q & wr_n;
    wire rd_fall = rd_q & ~rd_n;

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    // Settling delay between write strobe fall and data sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            settle_cnt <= '0;
        end else if (wr_fall) begin
            pend       <= 1'b1;
            settle_cnt <= '0;
        end else if (commit) begin
            pend <= 1'b0;
        end else if (pend) begin
            settle_cnt <= settle_cnt + SW'(1);
        end
    end

    assign commit = pend && (settle_cnt == SETTLE_LAST);

    // Chip select: latch the new level, drive the pin once the strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pend <= 1'b1;
            cs_n    <= 1'b1;
        end else begin
            if (commit && reg_sel == SDP_CTRL) cs_pend <= wdata[0];
            if (wr_rise) cs_n <= cs_pend;
        end
    end

    // Scratch bytes, one register each.
    for (genvar i = 0; i < SDP_NUM_SCR; i++) begin : g_scr
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (commit && reg_sel == 3'(int'(SDP_SCR_BASE) + i)) q <= wdata;
        end
        assign scr[i] = q;
    end

    // Exchange start from a sampled write or a read strobe edge.
    always_comb begin
        spi_start = 1'b0;
        spi_tx    = SDP_IDLE_BYTE;
        if (commit && reg_sel == SDP_XFER) begin
            spi_start = 1'b1;
            spi_tx    = wdata;
        end else if (rd_fall && reg_sel == SDP_XFER) begin
            spi_start = 1'b1;
        end
    end

    assign tmr_clr = commit && (reg_sel == SDP_TIMER);

    sdspi_shift #(.DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (spi_start),
        .tx_byte (spi_tx),
        .miso    (miso),
        .busy    (busy),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_byte (rx_byte)
    );

    sdspi_timer #(.TICK(TICK_CYCLES), .LIM_W(12), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .lim_in  (wdata),
        .expired (expired_w)
    );

    // Read data selection for the current register select.
    always_comb begin
        rdata = SDP_IDLE_BYTE;
        case (reg_sel)
            SDP_XFER:  rdata = rx_byte;
            SDP_CTRL:  rdata = CFG_BYTE;
            SDP_TIMER: rdata = {7'd0, expired_w};
            default: begin
                for (int i = 0; i < SDP_NUM_SCR; i++)
                    if (reg_sel == 3'(int'(SDP_SCR_BASE) + i)) rdata = scr[i];
            end
        endcase
    end

endmodule

// File: rtl/sdspi_port_chk.sv
// Property checker for sdspi_port, attached with bind.
// Observes strobes, SPI pins and the timer flag; drives nothing.
module sdspi_port_chk #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic cs_n,
    input logic busy,
    input logic sclk,
    input logic mosi,
    input logic expired,
    input logic tmr_clr
);
    int unsigned bcnt;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else bcnt <= 0;
    end

    // R6: chip select moves only on the edge after the strobe is released.
    a_r6_cs_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cs_n) && $past(rst_n)) |-> ($past(wr_n) && !$past(wr_n, 2)));

    // R2: serial clock idles low outside an exchange.
    a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R2: data is settled when the serial clock rises.
    a_r2_mosi_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R4: an exchange never runs past sixteen half periods.
    a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt < 32'(16 * DIV)));

    // R10: an expired timer stays expired until it is rewritten.
    a_r10_expired_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !tmr_clr) |=> expired);

endmodule

bind sdspi_port sdspi_port_chk #(.DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .cs_n    (cs_n),
    .busy    (busy),
    .sclk    (sclk),
    .mosi    (mosi),
    .expired (expired_w),
    .tmr_clr (tmr_clr)
);

// File: tb/sdspi_port_bench.sv
// Self-checking bench for sdspi_port with a small configuration.
module sdspi_port_bench;
    localparam int         DIV    = 2;
    localparam int         TICK   = 4;
    localparam int         SETTLE = 3;
    localparam int         CW     = 12;
    localparam logic [7:0] CFG    = 8'hA6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       busy, sclk, mosi, cs_n;
    logic       miso;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] slave_sh = 8'h00;
    logic [7:0] mosi_cap = 8'h00;
    int         rises = 0;

    always #2 clk = ~clk;

    sdspi_port #(
        .CLK_DIV(DIV), .TICK_CYCLES(TICK), .SETTLE_CYCLES(SETTLE),
        .CNT_W(CW), .CFG_BYTE(CFG)
    ) u_sdspi_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .rdata(rdata), .busy(busy), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // Card model: mode 0, presents MSB first, shifts on falling sclk.
    assign miso = slave_sh[7];
    always @(posedge sclk) begin
        mosi_cap = {mosi_cap[6:0], mosi};
        rises = rises + 1;
    end
    always @(negedge sclk) slave_sh = {slave_sh[6:0], 1'b0};

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act %0d cycles exp < 190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    // Write cycle: strobe low for SETTLE+2 negedges, then released.
    task automatic bus_wr(input logic [2:0] s, input logic [7:0] d);
        reg_sel = s; wdata = d; wr_n = 1'b0;
        repeat (SETTLE + 2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Read cycle; waits on busy before taking the data.
    task automatic bus_rd(input logic [2:0] s, output logic [7:0] d);
        reg_sel = s; rd_n = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        d = rdata;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b1 && busy == 1'b0,
            "R1 pins", {cs_n, sclk, mosi, busy}, 4'b1010);
        for (int s = 2; s <= 6; s++) begin
            reg_sel = 3'(s); #1;
            chk(rdata == 8'h00, "R1 scratch", rdata, 0);
        end
        reg_sel = 3'd7; #1;
        chk(rdata == 8'h01, "R1 timer", rdata, 1);

        // R2/R3: every byte value both ways
        for (int v = 0; v < 256; v++) begin
            slave_sh = 8'(v ^ 8'h3C); rises = 0;
            bus_wr(3'd0, 8'(v));
            wait_idle();
            chk(mosi_cap == 8'(v), "R2 mosi", mosi_cap, v);
            chk(rises == 8, "R2 pulses", rises, 8);
            slave_sh = 8'(v); rises = 0;
            bus_rd(3'd0, d);
            chk(mosi_cap == 8'hFF, "R3 idle tx", mosi_cap, 8'hFF);
            chk(d == 8'(v), "R3 rx", d, v);
            chk(rises == 8, "R3 pulses", rises, 8);
        end

        // R2: sclk half period is DIV cycles
        begin
            int hi;
            slave_sh = 8'h00;
            reg_sel = 3'd0; rd_n = 1'b0;
            @(negedge clk);
            while (!sclk) @(negedge clk);
            hi = 0;
            while (sclk) begin hi++; @(negedge clk); end
            chk(hi == DIV, "R2 half period", hi, DIV);
            rd_n = 1'b1;
            wait_idle();
        end

        // R4: start while busy is dropped
        slave_sh = 8'h00; rises = 0;
        bus_wr(3'd0, 8'h96);
        chk(busy == 1'b1, "R4 busy", busy, 1);
        bus_wr(3'd0, 8'h5A);
        reg_sel = 3'd0; rd_n = 1'b0; @(negedge clk); rd_n = 1'b1;
        wait_idle();
        repeat (4) @(negedge clk);
        chk(mosi_cap == 8'h96 && rises == 8, "R4 ignored", {mosi_cap, 8'(rises)}, {8'h96, 8'd8});
        chk(busy == 1'b0, "R4 idle", busy, 0);

        // R5: configuration byte is fixed
        bus_rd(3'd1, d);
        chk(d == CFG, "R5 cfg", d, CFG);
        bus_wr(3'd1, ~CFG);
        bus_rd(3'd1, d);
        chk(d == CFG, "R5 cfg after write", d, CFG);
        bus_wr(3'd1, 8'h01);
        repeat (2) @(negedge clk);

        // R6: chip select moves after strobe release, bit 0 only
        for (int r = 0; r < 4; r++) begin
            logic [7:0] cv;
            logic       old;
            cv = (r % 2 == 0) ? 8'hFE : 8'h01;
            old = cs_n;
            reg_sel = 3'd1; wdata = cv; wr_n = 1'b0;
            repeat (SETTLE + 2) @(negedge clk);
            chk(cs_n == old, "R6 held during strobe", cs_n, old);
            wr_n = 1'b1;
            @(negedge clk);
            chk(cs_n == cv[0], "R6 after release", cs_n, cv[0]);
        end

        // R7: scratch bytes independent
        for (int p = 0; p < 3; p++) begin
            for (int s = 2; s <= 6; s++) bus_wr(3'(s), 8'(s * 37 + p * 91));
            for (int s = 2; s <= 6; s++) begin
                bus_rd(3'(s), d);
                chk(d == 8'(s * 37 + p * 91), "R7 scratch", d, 8'(s * 37 + p * 91));
            end
        end

        // R8: data taken exactly SETTLE cycles after strobe seen low
        for (int s = 2; s <= 6; s++) begin
            reg_sel = 3'(s); wdata = 8'hEE; wr_n = 1'b0;
            for (int k = 1; k <= SETTLE + 2; k++) begin
                @(negedge clk);
                if (k == SETTLE) wdata = 8'(s + 8'h40);
                if (k == SETTLE + 1) wdata = 8'h11;
            end
            wr_n = 1'b1;
            @(negedge clk);
            bus_rd(3'(s), d);
            chk(d == 8'(s + 8'h40), "R8 sample edge", d, 8'(s + 8'h40));
        end

        // R9: exact expiry edge for several limits
        for (int n = 0; n <= 6; n++) begin
            int kexp;
            kexp = 1 + SETTLE + 10 * n * TICK;
            reg_sel = 3'd7; wdata = 8'(n); wr_n = 1'b0;
            for (int k = 1; k <= kexp; k++) begin
                @(negedge clk);
                if (k == SETTLE + 2) wr_n = 1'b1;
                if (n > 0 && k == kexp - 1)
                    chk(rdata == 8'h00, "R9 before limit", rdata, 0);
                if (k == kexp)
                    chk(rdata == 8'h01, "R9 at limit", rdata, 1);
            end
            wr_n = 1'b1;
            @(negedge clk);
        end

        // R10: count saturates, flag stays set
        bus_wr(3'd7, 8'd1);
        repeat (((1 << CW) + 20) * TICK) @(negedge clk);
        reg_sel = 3'd7; #1;
        chk(rdata == 8'h01, "R10 saturate", rdata, 1);

        summary();
        $finish;
    end
endmodule